// File: doc/BRIEF.md
# Serial Transmit Engine with Queued Words

This block is the sending side of an asynchronous serial port. A host pushes 9-bit words into a 16-entry queue. A shift engine, stepped by a tick input that runs at sixteen times the bit rate, pulls one word at a time and drives it onto a single line. The frame is a low start bit, a payload that depends on the chosen frame mode, and a high stop period of selectable length. Parity can be odd or even. When flow gating is enabled, a deasserted clear-to-send input keeps a new frame from starting.

The host sees four level flags on the queue: everything drained, at most half occupied, full, and not empty. A 3-bit mask selects which of these flags drives the interrupt output. A flush strobe empties the queue without cutting short the frame already on the line. Address decode, baud tick generation and interrupt routing sit outside the block.

Top module: `sertx_core`

## Requirements
- R1: After reset `txd` is 1, `st_empty` and `st_half` are 1, `st_full` and `st_nempty` are 0, and with `irq_mask` at 0 `irq` is 0.
- R2: A frame starts with `txd` low for 16 ticks. Payload bits follow, least significant first, each held for 16 ticks. The line is high between frames.
- R3: `cfg_mode` picks the payload. 3'b001 sends data[7:0]. 3'b011 sends data[6:0] and then a parity bit. 3'b100 sends data[8:0]. 3'b101 sends data[7:0] and then data[8] as a wake-up bit. 3'b111 sends data[7:0] and then a parity bit. Every other code behaves as 3'b001.
- R4: When `cfg_odd` is 1, the parity bit makes the count of ones across the data bits and the parity bit odd. When `cfg_odd` is 0, that count is even.
- R5: `cfg_stop` sets how long the stop level is held: 2'b00 gives 8 ticks, 2'b01 gives 16, 2'b10 gives 24 and 2'b11 gives 32. With back-to-back queued words, successive start edges are therefore 16*(1+payload bits)+stop ticks apart.
- R6: The queue holds 16 words and sends them in write order. `st_full` is 1 when it holds 16. A write while it is full is dropped and leaves the queued words unchanged.
- R7: `st_empty` is 1 only when the queue is empty and no frame is in progress. `st_half` is 1 when the queue holds at most 8 words. `st_nempty` is 1 when the queue holds at least one word.
- R8: A `flush` pulse empties the queue by the next cycle. A frame already on the line finishes unchanged. A write in the same cycle as `flush` is discarded.
- R9: When `cfg_cts_en` is 1 and the synchronized `cts_n` is 1, no new frame starts. A frame in progress always completes. When `cfg_cts_en` is 0, `cts_n` has no effect.
- R10: `irq` is the OR of `irq_mask[0]&st_empty`, `irq_mask[1]&st_half` and `irq_mask[2]&st_nempty`.
- R11: Mode, parity sense and stop length are captured when a frame starts. Changing them mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 9 | Word to queue |
| flush | input | 1 | Empty the queue |
| cfg_mode | input | 3 | Frame mode code |
| cfg_stop | input | 2 | Stop length code |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_cts_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low |
| irq_mask | input | 3 | Interrupt enables: [0] empty, [1] half, [2] not-empty |
| txd | output | 1 | Serial line |
| st_empty | output | 1 | Queue and shifter empty |
| st_half | output | 1 | Queue at least half empty |
| st_full | output | 1 | Queue full |
| st_nempty | output | 1 | Queue not empty |
| irq | output | 1 | Masked interrupt request |

## Verification
A corrupt queue pointer or count shows at the flags within one cycle. It also shows on the line as a missing, repeated or reordered word one frame later, so the bench drains full queues and compares every word in order. A wrong tick count or bit counter in the shifter moves the start edge of the next frame, so the spacing of back-to-back start edges is measured in ticks for every stop code. Holding the line with flow gating lets the flags be checked against an exact, frozen occupancy.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

   localparam int SX_WORD_W = 9;

   typedef logic [SX_WORD_W-1:0] sx_word_t;

   typedef enum logic [1:0] {
      SX_IDLE  = 2'd0,
      SX_START = 2'd1,
      SX_DATA  = 2'd2,
      SX_STOP  = 2'd3
   } sx_state_e;

   localparam logic [2:0] SX_M_8  = 3'b001;
   localparam logic [2:0] SX_M_7P = 3'b011;
   localparam logic [2:0] SX_M_9  = 3'b100;
   localparam logic [2:0] SX_M_8W = 3'b101;
   localparam logic [2:0] SX_M_8P = 3'b111;

   typedef struct packed {
      logic [3:0] nbits;
      sx_word_t   bits;
   } sx_payload_t;

   // Payload bits in line order (bit 0 first) and how many of them are sent.
   function automatic sx_payload_t sx_build(input logic [2:0] mode,
                                            input sx_word_t   d,
                                            input logic       odd);
      sx_payload_t p;
      p.bits  = '0;
      p.nbits = 4'd8;
      case (mode)
         SX_M_7P: begin
            p.bits[6:0] = d[6:0];
            p.bits[7]   = (^d[6:0]) ^ odd;
            p.nbits     = 4'd8;
         end
         SX_M_9, SX_M_8W: begin
            p.bits  = d;
            p.nbits = 4'd9;
         end
         SX_M_8P: begin
            p.bits[7:0] = d[7:0];
            p.bits[8]   = (^d[7:0]) ^ odd;
            p.nbits     = 4'd9;
         end
         default: begin
            p.bits[7:0] = d[7:0];
            p.nbits     = 4'd8;
         end
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sertx_fifo.sv
`timescale 1ns/1ps
module sertx_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 9
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       wr_en,
   input  logic [WIDTH-1:0]           wr_data,
   input  logic                       rd_en,
   output logic [WIDTH-1:0]           rd_data,
   output logic [$clog2(DEPTH):0]     count
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [AW:0]      cnt;
   logic             wr_ok, rd_ok;

   assign wr_ok = wr_en && !flush && (cnt != FULL_CNT);
   assign rd_ok = rd_en && !flush && (cnt != '0);

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (wr_ok) wptr <= wptr + 1'b1;
         if (rd_ok) rptr <= rptr + 1'b1;
         cnt <= cnt + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
      end
   end

   assign rd_data = mem[rptr];
   assign count   = cnt;

   // R6: a write into a full queue without a pop leaves it untouched
   p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == FULL_CNT && wr_en && !rd_en && !flush) |=> ($stable(cnt) && $stable(wptr)));

   // R8: flush empties the queue on the next cycle
   p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt == '0));

endmodule

// File: rtl/sertx_shifter.sv
`timescale 1ns/1ps
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       avail,
   input  logic       hold,
   input  sx_word_t   din,
   input  logic [2:0] mode,
   input  logic [1:0] stop,
   input  logic       odd,
   output logic       load,
   output logic       txd,
   output logic       idle
);
   localparam int CW   = $clog2(2*OVS);
   localparam int HALF = OVS/2;
   localparam logic [CW-1:0] BIT_LAST = CW'(OVS-1);

   sx_state_e   state;
   sx_word_t    shreg;
   logic [3:0]  nleft;
   logic [CW-1:0] tcnt;
   logic [CW-1:0] stop_last;
   sx_payload_t pl;

   assign pl   = sx_build(mode, din, odd);
   assign load = (state == SX_IDLE) && avail && !hold;
   assign idle = (state == SX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SX_IDLE;
         shreg     <= '0;
         nleft     <= '0;
         tcnt      <= '0;
         stop_last <= '0;
      end else begin
         case (state)
            SX_IDLE: begin
               if (load) begin
                  state     <= SX_START;
                  shreg     <= pl.bits;
                  nleft     <= pl.nbits;
                  tcnt      <= '0;
                  stop_last <= CW'(HALF * (int'(stop) + 1) - 1);
               end
            end
            SX_START: begin
               if (tick) begin
                  if (tcnt == BIT_LAST) begin
                     tcnt  <= '0;
                     state <= SX_DATA;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            SX_DATA: begin
               if (tick) begin
                  if (tcnt == BIT_LAST) begin
                     tcnt  <= '0;
                     shreg <= shreg >> 1;
                     nleft <= nleft - 1'b1;
                     if (nleft == 4'd1) state <= SX_STOP;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            SX_STOP: begin
               if (tick) begin
                  if (tcnt == stop_last) begin
                     tcnt  <= '0;
                     state <= SX_IDLE;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            default: state <= SX_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         SX_START: txd = 1'b0;
         SX_DATA:  txd = shreg[0];
         default:  txd = 1'b1;
      endcase
   end

   // R9: a gated engine never leaves idle
   p_cts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SX_IDLE && hold) |=> (state == SX_IDLE));

   // R2: the cycle after a word is taken the line is at the start level
   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !txd);

endmodule

// File: rtl/sertx_status.sv
`timescale 1ns/1ps
module sertx_status #(
   parameter int DEPTH = 16
) (
   input  logic [$clog2(DEPTH):0] count,
   input  logic                   idle,
   input  logic [2:0]             mask,
   output logic                   te,
   output logic                   the,
   output logic                   tf,
   output logic                   tne,
   output logic                   irq
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH/2);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   assign tne = (count != '0);
   assign tf  = (count == FULL_CNT);
   assign the = (count <= HALF_CNT);
   assign te  = !tne && idle;
   assign irq = (mask[0] && te) || (mask[1] && the) || (mask[2] && tne);

   always_comb begin
      // R7: a drained block is always at least half empty and never full
      p_empty_flags_r7: assert (!te || (the && !tf));
      // R10: no interrupt without an enabled source
      p_irq_src_r10: assert (!irq || (mask != 3'b000));
   end

endmodule

// File: rtl/sertx_core.sv
`timescale 1ns/1ps
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int WIDTH    = SX_WORD_W,
   parameter int OVS      = 16,
   parameter int CTS_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick16,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             flush,
   input  logic [2:0]       cfg_mode,
   input  logic [1:0]       cfg_stop,
   input  logic             cfg_odd,
   input  logic             cfg_cts_en,
   input  logic             cts_n,
   input  logic [2:0]       irq_mask,
   output logic             txd,
   output logic             st_empty,
   output logic             st_half,
   output logic             st_full,
   output logic             st_nempty,
   output logic             irq
);
   localparam int AW = $clog2(DEPTH);

   // Elaboration-time parameter checks
   if (WIDTH != SX_WORD_W) begin : g_bad_width
      $error("sertx_core: WIDTH must equal the package word width");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("sertx_core: DEPTH must be a power of two, at least 2");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("sertx_core: OVS must be even and at least 4");
   end
   if (CTS_SYNC < 0 || CTS_SYNC > 4) begin : g_bad_sync
      $error("sertx_core: CTS_SYNC must be 0 to 4");
   end

   logic          cts_q;
   logic          hold;
   logic          load;
   logic          sh_idle;
   logic [AW:0]   count;
   sx_word_t      head;

   if (CTS_SYNC == 0) begin : g_cts_direct
      assign cts_q = cts_n;
   end else begin : g_cts_sync
      logic [CTS_SYNC-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[CTS_SYNC-2+1-1:0], cts_n} >> 0;
      end
      assign cts_q = sync_q[CTS_SYNC-1];
   end

   assign hold = cfg_cts_en && cts_q;

   sertx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (load),
      .rd_data (head),
      .count   (count)
   );

   sertx_shifter #(.OVS(OVS)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick16),
      .avail (count != '0),
      .hold  (hold),
      .din   (head),
      .mode  (cfg_mode),
      .stop  (cfg_stop),
      .odd   (cfg_odd),
      .load  (load),
      .txd   (txd),
      .idle  (sh_idle)
   );

   sertx_status #(.DEPTH(DEPTH)) u_stat (
      .count (count),
      .idle  (sh_idle),
      .mask  (irq_mask),
      .te    (st_empty),
      .the   (st_half),
      .tf    (st_full),
      .tne   (st_nempty),
      .irq   (irq)
   );

endmodule

// File: tb/sim_sertx_core.sv
`timescale 1ns/1ps
module sim_sertx_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic       flush = 1'b0;
   logic [2:0] cfg_mode = 3'b001;
   logic [1:0] cfg_stop = 2'b01;
   logic       cfg_odd = 1'b0;
   logic       cfg_cts_en = 1'b0;
   logic       cts_n = 1'b0;
   logic [2:0] irq_mask = 3'b000;
   logic       txd, st_empty, st_half, st_full, st_nempty, irq;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   sertx_core u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
      .flush(flush), .cfg_mode(cfg_mode), .cfg_stop(cfg_stop), .cfg_odd(cfg_odd),
      .cfg_cts_en(cfg_cts_en), .cts_n(cts_n), .irq_mask(irq_mask), .txd(txd),
      .st_empty(st_empty), .st_half(st_half), .st_full(st_full),
      .st_nempty(st_nempty), .irq(irq)
   );

   always #2.5 clk = ~clk;

   // tick every fourth clock, driven away from the sampling edge
   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         tick16 = (div == 3);
         div = (div + 1) % 4;
      end
   end

   // line monitor: samples each bit in the middle of its 16 ticks
   logic [15:0] capt [0:63];
   int          capt_n = 0;
   int          edge_t [0:63];
   int          edge_n = 0;
   int          mon_n = 8;
   int          gticks = 0;
   bit          in_frame = 0;
   int          tc = 0;
   logic [15:0] bits = '0;
   logic        txd_prev = 1'b1;

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (tick16) gticks++;
            if (!in_frame && txd_prev && !txd) begin
               in_frame = 1;
               tc = 0;
               bits = '0;
               if (edge_n < 64) edge_t[edge_n] = gticks;
               edge_n++;
            end else if (in_frame && tick16) begin
               tc++;
               if (tc % 16 == 8) begin
                  bits[tc/16] = txd;
                  if (tc/16 == mon_n + 1) begin
                     in_frame = 0;
                     if (capt_n < 64) capt[capt_n] = bits;
                     capt_n++;
                  end
               end
            end
            txd_prev = txd;
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int nbits_of(input int mode);
      if (mode == 4 || mode == 5 || mode == 7) return 9;
      return 8;
   endfunction

   // expected line bits: [0] start, [1..n] payload, [n+1] stop
   function automatic int frame_of(input int mode, input logic [8:0] d, input bit odd);
      logic [8:0] pl;
      int ones;
      int n;
      int f;
      pl = '0;
      ones = 0;
      n = nbits_of(mode);
      if (mode == 3) begin
         for (int i = 0; i < 7; i++) begin pl[i] = d[i]; ones += int'(d[i]); end
         pl[7] = ((ones % 2) == 1) ^ odd;
      end else if (mode == 4 || mode == 5) begin
         pl = d;
      end else if (mode == 7) begin
         for (int i = 0; i < 8; i++) begin pl[i] = d[i]; ones += int'(d[i]); end
         pl[8] = ((ones % 2) == 1) ^ odd;
      end else begin
         for (int i = 0; i < 8; i++) pl[i] = d[i];
      end
      f = 0;
      for (int i = 0; i < n; i++) f[i+1] = pl[i];
      f[n+1] = 1'b1;
      return f;
   endfunction

   task automatic push(input logic [8:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic push2(input logic [8:0] a, input logic [8:0] b);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = a;
      @(negedge clk);
      wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_te(input int limit);
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (st_empty) break;
      end
   endtask

   task automatic wait_edge(input int from);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (edge_n > from) break;
      end
   endtask

   task automatic set_cfg(input int mode, input bit odd, input int stop);
      @(negedge clk);
      cfg_mode = 3'(mode);
      cfg_odd = odd;
      cfg_stop = 2'(stop);
      mon_n = nbits_of(mode);
   endtask

   task automatic send_one(input string req, input int mode, input logic [8:0] d, input bit odd);
      int base;
      set_cfg(mode, odd, 1);
      base = capt_n;
      push(d);
      wait_te(4000);
      check(req, "frame count", capt_n - base, 1);
      check(req, "frame bits", int'(capt[base]), frame_of(mode, d, odd));
   endtask

   task automatic t_reset();
      check("R1", "txd", int'(txd), 1);
      check("R1", "empty", int'(st_empty), 1);
      check("R1", "half", int'(st_half), 1);
      check("R1", "full", int'(st_full), 0);
      check("R1", "nempty", int'(st_nempty), 0);
      check("R1", "irq", int'(irq), 0);
   endtask

   task automatic t_modes();
      send_one("R2 R3 8-bit", 1, 9'h1A5, 0);
      send_one("R3 7+parity even", 3, 9'h0D3, 0);
      send_one("R4 7+parity odd", 3, 9'h0D3, 1);
      send_one("R3 9-bit", 4, 9'h155, 0);
      send_one("R3 wake", 5, 9'h13C, 0);
      send_one("R4 8+parity even", 7, 9'h0B6, 0);
      send_one("R4 8+parity odd", 7, 9'h0B6, 1);
      send_one("R3 reserved code", 0, 9'h1C3, 0);
      send_one("R3 reserved code 6", 6, 9'h05A, 1);
   endtask

   task automatic t_stop();
      for (int s = 0; s < 4; s++) begin
         int e0;
         set_cfg(1, 0, s);
         e0 = edge_n;
         push2(9'h011, 9'h0EE);
         wait_te(6000);
         check("R5", "edge count", edge_n - e0, 2);
         check("R5", "start spacing", edge_t[e0+1] - edge_t[e0], 144 + 8*(s+1));
      end
   endtask

   task automatic t_fifo();
      int base;
      set_cfg(1, 0, 1);
      cfg_cts_en = 1'b1;
      cts_n = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) push(9'(8'h30 + i));
      check("R7", "half at 8", int'(st_half), 1);
      check("R7", "nempty at 8", int'(st_nempty), 1);
      check("R7", "empty at 8", int'(st_empty), 0);
      check("R6", "full at 8", int'(st_full), 0);
      push(9'h038);
      check("R7", "half at 9", int'(st_half), 0);
      for (int i = 9; i < 16; i++) push(9'(8'h30 + i));
      check("R6", "full at 16", int'(st_full), 1);
      push(9'h0EE);
      check("R6", "full after drop", int'(st_full), 1);
      base = capt_n;
      @(negedge clk);
      cts_n = 1'b0;
      wait_te(20000);
      check("R6", "drained frames", capt_n - base, 16);
      for (int i = 0; i < 16; i++)
         check("R6", "order", int'(capt[base+i]), frame_of(1, 9'(8'h30 + i), 0));
   endtask

   task automatic t_irq_flush();
      cfg_cts_en = 1'b1;
      cts_n = 1'b1;
      repeat (4) @(negedge clk);
      irq_mask = 3'b001;
      @(negedge clk);
      check("R10", "empty source", int'(irq), 1);
      irq_mask = 3'b100;
      @(negedge clk);
      check("R10", "nempty masked", int'(irq), 0);
      push(9'h077);
      check("R10", "nempty source", int'(irq), 1);
      irq_mask = 3'b010;
      @(negedge clk);
      check("R10", "half source", int'(irq), 1);
      irq_mask = 3'b001;
      @(negedge clk);
      check("R10", "empty gone", int'(irq), 0);
      irq_mask = 3'b000;
      push(9'h078);
      push(9'h079);
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      check("R8", "flushed nempty", int'(st_nempty), 0);
      check("R8", "flushed empty", int'(st_empty), 1);
      @(negedge clk);
      flush = 1'b1;
      wr_en = 1'b1;
      wr_data = 9'h07A;
      @(negedge clk);
      flush = 1'b0;
      wr_en = 1'b0;
      check("R8", "write with flush", int'(st_nempty), 0);
      cts_n = 1'b0;
      repeat (800) @(negedge clk);
      check("R8", "nothing sent", int'(st_empty), 1);
   endtask

   task automatic t_flush_mid();
      int base;
      int e0;
      set_cfg(1, 0, 1);
      cfg_cts_en = 1'b1;
      cts_n = 1'b0;
      repeat (4) @(negedge clk);
      base = capt_n;
      e0 = edge_n;
      push2(9'h0C1, 9'h0C2);
      wait_edge(e0);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      wait_te(4000);
      repeat (800) @(negedge clk);
      check("R8", "frames after flush", capt_n - base, 1);
      check("R8", "frame kept", int'(capt[base]), frame_of(1, 9'h0C1, 0));
   endtask

   task automatic t_cts();
      int base;
      int e0;
      set_cfg(1, 0, 1);
      cfg_cts_en = 1'b1;
      cts_n = 1'b1;
      repeat (4) @(negedge clk);
      base = capt_n;
      e0 = edge_n;
      push(9'h0A3);
      repeat (400) @(negedge clk);
      check("R9", "held edges", edge_n - e0, 0);
      check("R9", "held line", int'(txd), 1);
      check("R9", "held queued", int'(st_nempty), 1);
      cts_n = 1'b0;
      wait_te(4000);
      check("R9", "released frame", int'(capt[base]), frame_of(1, 9'h0A3, 0));
      cfg_cts_en = 1'b0;
      cts_n = 1'b1;
      send_one("R9 gating off", 1, 9'h05C, 0);
      cfg_cts_en = 1'b1;
      cts_n = 1'b0;
      repeat (4) @(negedge clk);
      base = capt_n;
      e0 = edge_n;
      push(9'h0F0);
      wait_edge(e0);
      cts_n = 1'b1;
      wait_te(4000);
      check("R9", "mid-frame deassert count", capt_n - base, 1);
      check("R9", "mid-frame deassert bits", int'(capt[base]), frame_of(1, 9'h0F0, 0));
      cts_n = 1'b0;
      cfg_cts_en = 1'b0;
   endtask

   task automatic t_cfg_latch();
      int base;
      int e0;
      set_cfg(7, 1, 1);
      base = capt_n;
      e0 = edge_n;
      push(9'h0B7);
      wait_edge(e0);
      @(negedge clk);
      cfg_mode = 3'b001;
      cfg_odd = 1'b0;
      cfg_stop = 2'b11;
      wait_te(4000);
      check("R11", "frame count", capt_n - base, 1);
      check("R11", "frame bits", int'(capt[base]), frame_of(7, 9'h0B7, 1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_stop();
      t_fifo();
      t_irq_flush();
      t_flush_mid();
      t_cts();
      t_cfg_latch();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         vectors++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule